// File: doc/BRIEF.md
# Wrapped Burst Address Generator

This block produces the word address sequence for a synchronous burst read. A load strobe captures a start address and a mode. Each clock with the advance input high then moves the address on by one word. In continuous mode the address counts upward across the whole space and rolls over to zero after the top. In the three wrap modes the address runs from the start word to the end of its aligned group, returns to the group's first word, and stays inside that group.

Wrap bursts are capped at a fixed number of words. When the cap is reached a done flag rises and the address freezes until a new start address is loaded. In continuous mode a boundary flag marks the last word of every 64-word block, so the surrounding logic can insert whatever delay it needs before the next block.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, addr is 0, done is 0, boundary is 0 and the mode is continuous.
- R2: A cycle with load high sets addr to start_addr on the next clock and restarts the word count, whatever advance is. Load takes priority over advance.
- R3: Mode code 1, 2 or 3 selects wrap over a group of 8, 16 or 32 words. The group is aligned to its own size. Addresses run upward from the start word, and the group's last word is followed by the group's first word.
- R4: In a wrap mode, the address bits above the group offset never change between loads.
- R5: Mode code 0 is continuous: each accepted advance adds one to addr, and the highest address is followed by 0.
- R6: A clock with advance low and load low leaves addr unchanged.
- R7: In a wrap mode, done rises once 127 advances have been accepted after the load, which is 128 words including the start word. Done is never high in continuous mode.
- R8: While done is high, advance is ignored and addr holds until the next load. The load clears done.
- R9: boundary is high exactly when the mode is continuous and the low six bits of addr are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Captures start_addr and mode |
| start_addr | input | ADDR_W | First word of the burst |
| mode | input | 2 | 0 continuous, 1 wrap 8, 2 wrap 16, 3 wrap 32 |
| advance | input | 1 | Step to the next word |
| addr | output | ADDR_W | Current word address |
| boundary | output | 1 | Current word ends a 64-word block (continuous mode) |
| done | output | 1 | Wrap word limit reached |

## Verification
All four modes are swept from starts that sit at the bottom of a group, in its middle, on its last word, on 3Eh and 3Fh, and just below the top of the address space. Mid-group starts show that a wrap returns to the aligned group base and not to the start word. Starts near the top separate a continuous rollover to zero from a wrap that stays inside its group. Each burst runs past the word limit with advance pulled low on a regular pattern. This checks that held cycles are not counted, that the limit falls on exactly the 128th word, and that an advance after done is dropped.

// File: rtl/burst_pkg.sv
package burst_pkg;
   typedef enum logic [1:0] {
      MODE_CONT   = 2'd0,
      MODE_WRAP8  = 2'd1,
      MODE_WRAP16 = 2'd2,
      MODE_WRAP32 = 2'd3
   } burst_mode_e;

   localparam int BLOCK_BITS = 6;

   function automatic logic [2:0] group_bits(burst_mode_e m);
      case (m)
         MODE_WRAP8:  return 3'd3;
         MODE_WRAP16: return 3'd4;
         MODE_WRAP32: return 3'd5;
         default:     return 3'd0;
      endcase
   endfunction
endpackage

// File: rtl/burst_group_mask.sv
module burst_group_mask
   import burst_pkg::*;
#(
   parameter int ADDR_W = 23
) (
   input  burst_mode_e        mode_i,
   output logic [ADDR_W-1:0]  mask_o
);
   logic [2:0] gbits;
   logic       is_cont;

   assign gbits   = group_bits(mode_i);
   assign is_cont = (mode_i == MODE_CONT);

   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      assign mask_o[i] = is_cont | (int'(gbits) > i);
   end
endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr #(
   parameter int ADDR_W = 23
) (
   input  logic [ADDR_W-1:0] cur_i,
   input  logic [ADDR_W-1:0] mask_i,
   output logic [ADDR_W-1:0] next_o
);
   logic [ADDR_W-1:0] inc;

   assign inc    = cur_i + ADDR_W'(1);
   assign next_o = (cur_i & ~mask_i) | (inc & mask_i);
endmodule

// File: rtl/burst_limit_counter.sv
module burst_limit_counter #(
   parameter int LIMIT = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic enable_i,
   input  logic step_i,
   output logic done_o
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   if (LIMIT < 2) begin : g_bad_limit
      $error("LIMIT must be at least 2");
   end

   assign done_o = enable_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cnt_q <= '0;
      else if (clear_i)                      cnt_q <= '0;
      else if (enable_i && step_i && !done_o) cnt_q <= cnt_q + CW'(1);
   end

   AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST); // R7
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int ADDR_W     = 23,
   parameter int WRAP_LIMIT = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [1:0]        mode,
   input  logic              advance,
   output logic [ADDR_W-1:0] addr,
   output logic              boundary,
   output logic              done
);
   localparam logic [BLOCK_BITS-1:0] BLK_LAST = '1;

   if (ADDR_W < BLOCK_BITS) begin : g_bad_width
      $error("ADDR_W must cover at least one 64-word block");
   end

   burst_mode_e       mode_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] grp_mask;
   logic [ADDR_W-1:0] addr_nxt;
   logic              is_wrap;
   logic              lim_hit;

   assign is_wrap = (mode_q != MODE_CONT);

   burst_group_mask #(.ADDR_W(ADDR_W)) u_mask (
      .mode_i (mode_q),
      .mask_o (grp_mask)
   );

   burst_next_addr #(.ADDR_W(ADDR_W)) u_next (
      .cur_i  (addr_q),
      .mask_i (grp_mask),
      .next_o (addr_nxt)
   );

   burst_limit_counter #(.LIMIT(WRAP_LIMIT)) u_lim (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (load),
      .enable_i (is_wrap),
      .step_i   (advance),
      .done_o   (lim_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         mode_q <= MODE_CONT;
      end else if (load) begin
         addr_q <= start_addr;
         mode_q <= burst_mode_e'(mode);
      end else if (advance && !lim_hit) begin
         addr_q <= addr_nxt;
      end
   end

   assign addr     = addr_q;
   assign done     = lim_hit;
   assign boundary = !is_wrap && (addr_q[BLOCK_BITS-1:0] == BLK_LAST);

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (addr == $past(start_addr))); // R2
   AST_STAY_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && is_wrap) |=> ((addr & ~grp_mask) == ($past(addr) & ~grp_mask))); // R4
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !advance) |=> $stable(addr)); // R6
   AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !load) |=> $stable(addr)); // R8
   AST_CONT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && advance && !is_wrap) |=> (addr == $past(addr) + ADDR_W'(1))); // R5
   AST_NO_CONT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !is_wrap |-> !done); // R7
   AST_BOUNDARY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |-> !is_wrap); // R9
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
   localparam int AW = 23;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          load = 0;
   logic [AW-1:0] start_addr = '0;
   logic [1:0]    mode = 2'd0;
   logic          advance = 0;
   logic [AW-1:0] addr;
   logic          boundary;
   logic          done;

   int errors = 0;
   int checks = 0;

   int            m_mode;
   logic [AW-1:0] m_start;
   int            m_k;

   always #10 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .WRAP_LIMIT(128)) u_burst_addr_gen (
      .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
      .mode(mode), .advance(advance), .addr(addr), .boundary(boundary),
      .done(done)
   );

   function automatic logic [AW-1:0] exp_addr(int md, logic [AW-1:0] s, int k);
      logic [AW-1:0] sz;
      if (md == 0) return s + AW'(k);
      sz = AW'(4 << md);
      return (s & ~(sz - 1)) | ((s + AW'(k)) & (sz - 1));
   endfunction

   task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_now();
      logic [AW-1:0] ea;
      logic          ed;
      logic          eb;
      ea = exp_addr(m_mode, m_start, m_k);
      ed = (m_mode != 0) && (m_k >= 127);
      eb = (m_mode == 0) && (ea[5:0] == 6'h3F);
      chk(m_mode == 0 ? "R5 addr" : "R3 addr", addr, ea);
      chk(m_mode == 0 ? "R7 done(cont)" : "R7/R8 done", AW'(done), AW'(ed));
      chk("R9 boundary", AW'(boundary), AW'(eb));
   endtask

   task automatic do_load(int md, logic [AW-1:0] s);
      @(negedge clk);
      load = 1; start_addr = s; mode = 2'(md); advance = 1;
      @(posedge clk);
      m_mode = md; m_start = s; m_k = 0;
      @(negedge clk);
      load = 0; advance = 0;
      chk("R2 load start", addr, s);
   endtask

   task automatic run_burst(int steps);
      for (int i = 0; i < steps; i++) begin
         logic a;
         @(negedge clk);
         check_now();
         a = (i % 5) != 2;
         advance = a;
         @(posedge clk);
         if (a && !((m_mode != 0) && (m_k >= 127))) m_k++;
      end
      @(negedge clk);
      advance = 0;
      check_now();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      logic [AW-1:0] starts [7];
      starts = '{23'h0, 23'h39, 23'h3E, 23'h3F, 23'h25, 23'h7FFFFE, 23'h7FFFC1};
      repeat (3) @(negedge clk);
      chk("R1 reset addr", addr, '0);
      chk("R1 reset done", AW'(done), '0);
      chk("R1 reset boundary", AW'(boundary), '0);
      rst_n = 1;
      m_mode = 0; m_start = '0; m_k = 0;
      @(negedge clk);
      chk("R1 continuous after reset", addr, '0);
      for (int md = 0; md < 4; md++) begin
         for (int j = 0; j < 7; j++) begin
            do_load(md, starts[j]);
            run_burst(170);
         end
      end
      // R2 reload mid-burst restarts the word count
      do_load(1, 23'h39);
      run_burst(40);
      do_load(3, 23'h123);
      run_burst(165);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule